// File: doc/BRIEF.md
# Multi-Processor Device Interrupt Router

The block collects up to 64 device interrupt lines into one shared pending vector and steers them to four processors. Devices do not drive level lines into it. They pulse a set strobe or a clear strobe, each tagged with an interrupt number, and the block keeps the pending bit until it is cleared. Each processor owns a 64-bit enable mask. A per-processor routed vector holds that mask ANDed with the pending vector. A processor's interrupt output is high whenever its routed vector has any bit set.

Software reaches the block through a single-cycle register port with 64-bit registers spaced 64 bytes apart. Mask registers can be written and read. The pending vector and the routed vectors are read-only. Routed vectors are recomputed on the same clock edge as any mask write or strobe. An enabled pending source therefore reaches its processor on the next edge, and a masked source is withdrawn on the next edge.

Top module: `irq_route_top`

## Requirements
- R1: After reset every mask, the pending vector and every routed vector read zero, all `irq_o` bits are low and `err_o` is low.
- R2: The register index is `addr_i >> 6`, and the low six address bits are ignored. Index 0 is the pending vector. Index 1+c is the mask of processor c. Index 5+c is the routed vector of processor c. Read data appears on `rdata_o` in the cycle after the request.
- R3: A legal write to index 1+c replaces processor c's mask with `wdata_i`, effective from the next clock edge.
- R4: From the edge after any mask write or strobe, processor c's routed vector equals its mask ANDed with the pending vector.
- R5: `irq_o[c]` is high exactly when processor c's routed vector is nonzero, and it changes on the same edge as that vector.
- R6: A set strobe with number n sets pending bit n at the next edge.
- R7: A clear strobe with number n clears pending bit n. Clearing an already-clear bit changes no register and no output.
- R8: A set strobe and a clear strobe on the same number in the same cycle leave the bit set. On different numbers, both take effect.
- R9: An access whose `size_i` is not 3 (code 3 means 8 bytes; codes 0 to 2 mean 1, 2 and 4 bytes) pulses `err_o` in the next cycle, changes no state and returns zero data.
- R10: A write to index 0, a write to a routed-vector index, or any access to an index above 8 pulses `err_o` in the next cycle and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Byte offset of the access |
| size_i | input | 2 | log2 of access bytes; 3 is the only legal value |
| wdata_i | input | 64 | Write data |
| rdata_o | output | 64 | Read data, one cycle after the request |
| err_o | output | 1 | Illegal-access pulse, one cycle after the request |
| set_vld_i | input | 1 | Device set strobe |
| set_id_i | input | 6 | Interrupt number to set |
| clr_vld_i | input | 1 | Device clear strobe |
| clr_id_i | input | 6 | Interrupt number to clear |
| irq_o | output | 4 | Per-processor level interrupt |

## Verification
The bench sweeps every one of the 64 interrupt numbers under four different masks. This exposes a wrong bit index or a routed vector that is not recomputed on strobes, because either shows up as a missing or spurious `irq_o`. It enables and then masks an already-pending source: a design that only recomputes on strobes would hold the line high after masking. It also checks a repeated clear, a same-number set and clear (a clear-wins design loses the bit), and each illegal size and index. A design that lets a flagged write through would then show a changed mask or pending vector on readback.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam logic [1:0] SZ_DWORD = 2'd3;

  typedef enum logic [1:0] {
    KIND_RAW  = 2'd0,
    KIND_MASK = 2'd1,
    KIND_RES  = 2'd2,
    KIND_NONE = 2'd3
  } reg_kind_e;
endpackage

// File: rtl/irq_pend_reg.sv
module irq_pend_reg #(
  parameter int NUM_SRC = 64,
  localparam int ID_W = $clog2(NUM_SRC)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               set_vld_i,
  input  logic [ID_W-1:0]    set_id_i,
  input  logic               clr_vld_i,
  input  logic [ID_W-1:0]    clr_id_i,
  output logic [NUM_SRC-1:0] pend_d_o,
  output logic [NUM_SRC-1:0] pend_q_o
);
  logic [NUM_SRC-1:0] pend_q, pend_d;

  // clear first, set last: set wins on a collision
  always_comb begin
    pend_d = pend_q;
    if (clr_vld_i) pend_d[clr_id_i] = 1'b0;
    if (set_vld_i) pend_d[set_id_i] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= pend_d;
  end

  assign pend_d_o = pend_d;
  assign pend_q_o = pend_q;

  AST_SET_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_vld_i |=> pend_q[$past(set_id_i)]); // R6
  AST_CLR_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_vld_i && !(set_vld_i && set_id_i == clr_id_i)) |=> !pend_q[$past(clr_id_i)]); // R7
  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_vld_i && clr_vld_i && set_id_i == clr_id_i) |=> pend_q[$past(set_id_i)]); // R8
  AST_PEND_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_vld_i && !clr_vld_i) |=> $stable(pend_q)); // R7
endmodule

// File: rtl/irq_cpu_slice.sv
module irq_cpu_slice #(
  parameter int NUM_SRC = 64
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               mask_we_i,
  input  logic [NUM_SRC-1:0] wdata_i,
  input  logic [NUM_SRC-1:0] pend_d_i,
  output logic [NUM_SRC-1:0] mask_o,
  output logic [NUM_SRC-1:0] res_o,
  output logic               irq_o
);
  logic [NUM_SRC-1:0] mask_q, mask_d, res_q, res_d;
  logic               irq_q;

  assign mask_d = mask_we_i ? wdata_i : mask_q;
  assign res_d  = mask_d & pend_d_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      res_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      mask_q <= mask_d;
      res_q  <= res_d;
      irq_q  <= |res_d;
    end
  end

  assign mask_o = mask_q;
  assign res_o  = res_q;
  assign irq_o  = irq_q;

  AST_MASK_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_we_i |=> mask_q == $past(wdata_i)); // R3
  AST_MASK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mask_we_i |=> $stable(mask_q)); // R3
  AST_IRQ_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q == (res_q != '0)); // R5
endmodule

// File: rtl/irq_reg_port.sv
module irq_reg_port
  import irq_route_pkg::*;
#(
  parameter int NUM_CPU   = 4,
  parameter int DATA_W    = 64,
  parameter int ADDR_W    = 12,
  parameter int REG_SHIFT = 6,
  localparam int IDX_W = ADDR_W - REG_SHIFT
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           req_i,
  input  logic                           we_i,
  input  logic [ADDR_W-1:0]              addr_i,
  input  logic [1:0]                     size_i,
  input  logic [DATA_W-1:0]              pend_i,
  input  logic [NUM_CPU-1:0][DATA_W-1:0] mask_i,
  input  logic [NUM_CPU-1:0][DATA_W-1:0] res_i,
  output logic [NUM_CPU-1:0]             mask_we_o,
  output logic [DATA_W-1:0]              rdata_o,
  output logic                           err_o
);
  logic [IDX_W-1:0] idx;
  reg_kind_e        kind;
  logic             size_ok, bad;
  logic [DATA_W-1:0] rd_d, rdata_q;
  logic             err_q;

  assign idx     = addr_i[ADDR_W-1:REG_SHIFT];
  assign size_ok = (size_i == SZ_DWORD);

  always_comb begin
    if (int'(idx) == 0)                 kind = KIND_RAW;
    else if (int'(idx) <= NUM_CPU)      kind = KIND_MASK;
    else if (int'(idx) <= 2 * NUM_CPU)  kind = KIND_RES;
    else                                kind = KIND_NONE;
  end

  assign bad = req_i && (!size_ok || kind == KIND_NONE ||
                         (we_i && kind != KIND_MASK));

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_we
    assign mask_we_o[c] = req_i && we_i && !bad && (int'(idx) == c + 1);
  end

  always_comb begin
    rd_d = '0;
    if (req_i && !we_i && !bad) begin
      if (kind == KIND_RAW) rd_d = pend_i;
      for (int c = 0; c < NUM_CPU; c++) begin
        if (int'(idx) == c + 1)           rd_d = mask_i[c];
        if (int'(idx) == c + 1 + NUM_CPU) rd_d = res_i[c];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      rdata_q <= rd_d;
      err_q   <= bad;
    end
  end

  assign rdata_o = rdata_q;
  assign err_o   = err_q;

  AST_SIZE_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !size_ok) |=> (err_o && rdata_o == '0)); // R9
  AST_RO_WRITE_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && kind != KIND_MASK) |=> err_o); // R10
  AST_ERR_NO_WE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad |-> mask_we_o == '0); // R10
  AST_WE_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(mask_we_o)); // R3
endmodule

// File: rtl/irq_route_top.sv
module irq_route_top #(
  parameter int NUM_CPU   = 4,
  parameter int NUM_SRC   = 64,
  parameter int ADDR_W    = 12,
  parameter int REG_SHIFT = 6,
  localparam int ID_W = $clog2(NUM_SRC)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [1:0]         size_i,
  input  logic [NUM_SRC-1:0] wdata_i,
  output logic [NUM_SRC-1:0] rdata_o,
  output logic               err_o,
  input  logic               set_vld_i,
  input  logic [ID_W-1:0]    set_id_i,
  input  logic               clr_vld_i,
  input  logic [ID_W-1:0]    clr_id_i,
  output logic [NUM_CPU-1:0] irq_o
);
  logic [NUM_SRC-1:0]              pend_d, pend_q;
  logic [NUM_CPU-1:0][NUM_SRC-1:0] mask, res;
  logic [NUM_CPU-1:0]              mask_we;

  irq_pend_reg #(.NUM_SRC(NUM_SRC)) u_pend (
    .clk_i, .rst_ni,
    .set_vld_i, .set_id_i, .clr_vld_i, .clr_id_i,
    .pend_d_o (pend_d),
    .pend_q_o (pend_q)
  );

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    irq_cpu_slice #(.NUM_SRC(NUM_SRC)) u_slice (
      .clk_i, .rst_ni,
      .mask_we_i (mask_we[c]),
      .wdata_i   (wdata_i),
      .pend_d_i  (pend_d),
      .mask_o    (mask[c]),
      .res_o     (res[c]),
      .irq_o     (irq_o[c])
    );

    AST_ROUTE_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      res[c] == (mask[c] & pend_q)); // R4
  end

  irq_reg_port #(
    .NUM_CPU(NUM_CPU), .DATA_W(NUM_SRC), .ADDR_W(ADDR_W), .REG_SHIFT(REG_SHIFT)
  ) u_port (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .size_i,
    .pend_i    (pend_q),
    .mask_i    (mask),
    .res_i     (res),
    .mask_we_o (mask_we),
    .rdata_o, .err_o
  );
endmodule

// File: tb/irq_route_top_bench.sv
module irq_route_top_bench;
  localparam int CLK_P = 10;
  localparam int NC = 4;

  logic        clk = 0, rst_n = 0;
  logic        req = 0, we = 0;
  logic [11:0] addr = '0;
  logic [1:0]  size = 2'd3;
  logic [63:0] wdata = '0, rdata;
  logic        err;
  logic        set_v = 0, clr_v = 0;
  logic [5:0]  set_id = '0, clr_id = '0;
  logic [3:0]  irq;

  int n_chk = 0, n_fail = 0;
  logic [63:0] pend_m;
  logic [63:0] mask_m [NC];

  always #(CLK_P/2) clk = ~clk;

  irq_route_top u_irq_route_top (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .size_i(size), .wdata_i(wdata), .rdata_o(rdata), .err_o(err),
    .set_vld_i(set_v), .set_id_i(set_id), .clr_vld_i(clr_v), .clr_id_i(clr_id),
    .irq_o(irq)
  );

  task automatic chk(string req_tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req_tag, act, exp);
    end
  endtask

  task automatic access(input logic w, input int idx, input logic [5:0] off,
                        input logic [1:0] sz, input logic [63:0] d,
                        output logic [63:0] rd, output logic e);
    @(negedge clk);
    req = 1; we = w; addr = {idx[5:0], off}; size = sz; wdata = d;
    @(negedge clk);
    rd = rdata; e = err;
    req = 0; we = 0; size = 2'd3;
  endtask

  task automatic rd_reg(int idx, output logic [63:0] d);
    logic e;
    access(0, idx, 6'h0, 2'd3, '0, d, e);
  endtask

  task automatic wr_mask(int c, logic [63:0] d);
    logic [63:0] r; logic e;
    access(1, c + 1, 6'h0, 2'd3, d, r, e);
    mask_m[c] = d;
    chk("R3 mask write no err", e, 1'b0);
  endtask

  task automatic strobe(logic sv, logic [5:0] si, logic cv, logic [5:0] ci);
    @(negedge clk);
    set_v = sv; set_id = si; clr_v = cv; clr_id = ci;
    @(negedge clk);
    set_v = 0; clr_v = 0;
    if (cv) pend_m[ci] = 1'b0;
    if (sv) pend_m[si] = 1'b1;
  endtask

  task automatic chk_irq(string tag);
    for (int c = 0; c < NC; c++)
      chk(tag, irq[c], |(mask_m[c] & pend_m));
  endtask

  task automatic chk_all(string tag);
    logic [63:0] d;
    rd_reg(0, d); chk({tag, " pend"}, d, pend_m);
    for (int c = 0; c < NC; c++) begin
      rd_reg(1 + c, d); chk({tag, " mask"}, d, mask_m[c]);
      rd_reg(5 + c, d); chk({tag, " R4 res"}, d, mask_m[c] & pend_m);
    end
    chk_irq({tag, " R5 irq"});
  endtask

  initial begin
    #(CLK_P * 150000);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [63:0] d; logic e;
    pend_m = '0;
    for (int c = 0; c < NC; c++) mask_m[c] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 irq reset", irq, 4'h0);
    chk("R1 err reset", err, 1'b0);
    chk_all("R1");

    // R2: offset bits below 6 ignored
    wr_mask(2, 64'hDEAD_BEEF_0123_4567);
    access(0, 3, 6'h28, 2'd3, '0, d, e);
    chk("R2 low offset ignored", d, 64'hDEAD_BEEF_0123_4567);
    chk("R2 no err", e, 1'b0);

    // sweep all numbers under four masks
    wr_mask(0, '1);
    wr_mask(1, 64'h5555_5555_5555_5555);
    wr_mask(2, 64'hFFFF_FFFF_0000_0000);
    wr_mask(3, '0);
    for (int n = 0; n < 64; n++) begin
      strobe(1, n[5:0], 0, '0);
      chk_irq("R6 R5 set sweep");
      rd_reg(6, d); chk("R4 res1 sweep", d, mask_m[1] & pend_m);
      strobe(0, '0, 1, n[5:0]);
      chk_irq("R7 clr sweep");
    end
    chk_all("R7 after sweep");

    // mask a pending source on, then off
    strobe(1, 6'd5, 0, '0);
    chk("R5 masked pending", irq[3], 1'b0);
    wr_mask(3, 64'h20);
    chk("R3 R5 unmask fires", irq[3], 1'b1);
    wr_mask(3, '0);
    chk("R3 R5 mask withdraws", irq[3], 1'b0);
    chk_all("R4 after mask toggle");

    // repeated clear
    strobe(0, '0, 1, 6'd5);
    chk_all("R7 first clr");
    strobe(0, '0, 1, 6'd5);
    chk_all("R7 repeat clr");

    // collisions
    strobe(1, 6'd40, 1, 6'd40);
    rd_reg(0, d); chk("R8 set wins", d[40], 1'b1);
    strobe(1, 6'd41, 1, 6'd40);
    chk_all("R8 distinct ids");
    chk("R8 both applied", pend_m[41] && !pend_m[40], 1'b1);

    // illegal sizes
    for (int s = 0; s < 3; s++) begin
      access(1, 1, 6'h0, s[1:0], 64'h1234, d, e);
      chk("R9 size write err", e, 1'b1);
      access(0, 1, 6'h0, s[1:0], '0, d, e);
      chk("R9 size read err", e, 1'b1);
      chk("R9 size read zero", d, '0);
    end
    chk_all("R9 no change");

    // read-only and unmapped
    access(1, 0, 6'h0, 2'd3, '1, d, e); chk("R10 pend write err", e, 1'b1);
    for (int c = 0; c < NC; c++) begin
      access(1, 5 + c, 6'h0, 2'd3, '1, d, e); chk("R10 res write err", e, 1'b1);
    end
    access(0, 9, 6'h0, 2'd3, '0, d, e);  chk("R10 unmapped read err", e, 1'b1);
    access(1, 63, 6'h0, 2'd3, '1, d, e); chk("R10 unmapped write err", e, 1'b1);
    chk_all("R10 no change");

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule